// File: doc/BRIEF.md
# Fast-Page DRAM Controller with Interval Refresh

This block turns single-word requests from a synchronous requester into strobe sequences for an asynchronous fast-page DRAM. The DRAM holds 256K words of 16 bits and shares nine address pins between the row and the column. A request carries an 18-bit word address, write data, a two-bit byte mask and a read/write flag. The block opens a row with RAS, then runs one column cycle per access with the byte strobes. The row stays open afterwards, so a later request to the same row needs only a new column cycle. Reads come back as a word with a one-cycle valid pulse. The response port has no back-pressure.

A refresh scheduler counts controller cycles. Once per refresh interval it adds one owed refresh, and a full refresh window covers all 512 rows. Owed refreshes run as CAS-before-RAS cycles. A refresh is deferred while requests keep arriving, but only until the owed count reaches a small limit. At that limit it takes priority over new requests as soon as the current column cycle ends. All DRAM timings are given as parameters in nanoseconds and are rounded up to whole controller cycles.

The request port uses valid/ready. The requester holds valid, address, data, mask and flag unchanged until a clock edge where both valid and ready are high. Ready may depend on the address presented. It is high in the idle and row-open states unless a refresh is due. When a row is open, ready is high only for the open row or for a write whose mask is zero.

Top module: `fpdram_ctl`

## Requirements
- R1: During and directly after reset, RAS, both CAS strobes, the write strobe and the output enable are high, the data drive enable is low and the response valid is low.
- R2: A row activation presents address bits 17:9 on the DRAM address pins while RAS falls. The column cycle that follows presents bits 8:0 while CAS falls.
- R3: A request to the open row is served by a column cycle with no new RAS fall. A request to another row first raises RAS for at least the precharge count (two cycles by default) and only then activates the new row.
- R4: Mask bit 0 drives the lower CAS strobe, which covers data bits 7:0. Mask bit 1 drives the upper CAS strobe, which covers bits 15:8. A write with mask 00 is accepted and drives no CAS strobe. A read drives both strobes.
- R5: Writes use early-write timing. The write strobe is low for at least one cycle before CAS falls, and the data drive enable is high while CAS is low. The output enable is low only during reads and never at the same time as the write strobe.
- R6: Read data is captured a number of cycles after CAS falls equal to the CAS access count (one by default). It is returned with a response valid that is high for exactly one cycle.
- R7: A refresh drives both CAS strobes low while RAS is high, one cycle before RAS falls. RAS then stays low for the RAS access count. On average the block issues one refresh per interval, which is the refresh window divided by 512 rows and by the clock period.
- R8: While requests are waiting, owed refreshes are deferred until their count reaches the postpone limit (three by default). The owed count never goes above that limit, so over any stretch of traffic the number of refreshes stays within that limit plus one of the number of intervals elapsed.
- R9: A request to a row other than the open one is not accepted until that row has been activated. Until then ready stays low and the requester holds the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte mask: bit 0 lower byte, bit 1 upper byte |
| req_addr | input | 18 | Word address: row in 17:9, column in 8:0 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data |
| dram_a | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Shared write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
Several strobe rules are checked on every cycle by assertions:
- During a refresh, CAS falls before RAS.
- On a write, the write strobe leads CAS.
- The output enable never overlaps the write strobe.
- A mask-00 write moves no CAS strobe.
- A request accepted with the row open matches that row.
- The response pulse lasts one cycle.
- The owed-refresh count never goes above its limit.

Other behaviour can only be shown by the bench's scenarios, which run a behavioural memory on the pins:
- Byte merging and the returned read data.
- The exact capture cycle.
- The precharge gap on a row miss.
- Refresh rates over long idle stretches and over long runs of traffic.

// File: rtl/fpdram_pkg.sv
`timescale 1ns/1ps
package fpdram_pkg;
  localparam int DATA_W = 16;
  localparam int BE_W   = 2;

  typedef enum logic [2:0] {
    ST_CLOSED, ST_ACT, ST_COL, ST_OPEN, ST_PRE, ST_RCAS, ST_RRAS
  } seq_state_t;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int ns2cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m > d) ? m : d;
  endfunction
endpackage

// File: rtl/fpdram_refresh.sv
`timescale 1ns/1ps
module fpdram_refresh #(
  parameter int INTERVAL = 800,
  parameter int LIMIT    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_need,
  output logic ref_urgent
);
  localparam int TW = $clog2(INTERVAL);
  localparam int OW = $clog2(LIMIT + 2);

  logic [TW-1:0] tick_cnt;
  logic          tick;
  logic [OW-1:0] owed;

  assign tick = (tick_cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      owed     <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      case ({tick, ref_ack})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign ref_need   = (owed != '0);
  assign ref_urgent = (owed >= OW'(LIMIT));

  assert_owed_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(LIMIT));
  assert_ack_when_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> ref_need);
endmodule

// File: rtl/fpdram_seq.sv
`timescale 1ns/1ps
module fpdram_seq
  import fpdram_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int RCD_CYC = 2,
  parameter int CAC_CYC = 1,
  parameter int RP_CYC  = 2,
  parameter int RAS_CYC = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [BE_W-1:0]        req_be,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   ref_need,
  input  logic                   ref_urgent,
  output logic                   ref_ack,
  output logic [ROW_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_lcas_n,
  output logic                   dram_ucas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int AW    = ROW_W + COL_W;
  localparam int CNT_W = $clog2(max4(RCD_CYC, CAC_CYC, RP_CYC, RAS_CYC) + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_W-1:0]  open_row;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wd_q;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic null_wr, hit, ref_go, cas_phase;

  assign req_row = req_addr[AW-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign null_wr = req_we && (req_be == '0);
  assign hit     = (req_row == open_row);
  assign ref_go  = ref_urgent || (ref_need && !req_valid);

  always_comb begin
    case (state)
      ST_CLOSED: req_ready = !ref_go;
      ST_OPEN:   req_ready = !ref_go && (null_wr || hit);
      default:   req_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CLOSED;
      cnt       <= '0;
      open_row  <= '0;
      col_q     <= '0;
      we_q      <= 1'b0;
      be_q      <= '0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_CLOSED: begin
          cnt <= '0;
          if (ref_go) state <= ST_RCAS;
          else if (req_valid && !null_wr) begin
            state    <= ST_ACT;
            open_row <= req_row;
            col_q    <= req_col;
            we_q     <= req_we;
            be_q     <= req_be;
            wd_q     <= req_wdata;
          end
        end
        ST_ACT: begin
          if (cnt == CNT_W'(RCD_CYC - 1)) begin cnt <= '0; state <= ST_COL; end
          else cnt <= cnt + 1'b1;
        end
        ST_COL: begin
          if (cnt == CNT_W'(CAC_CYC)) begin
            cnt   <= '0;
            state <= ST_OPEN;
            if (!we_q) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dram_dq_in;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_OPEN: begin
          if (ref_go) state <= ST_PRE;
          else if (req_valid && !null_wr) begin
            if (hit) begin
              state <= ST_COL;
              col_q <= req_col;
              we_q  <= req_we;
              be_q  <= req_be;
              wd_q  <= req_wdata;
            end else state <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (cnt == CNT_W'(RP_CYC - 1)) begin cnt <= '0; state <= ST_CLOSED; end
          else cnt <= cnt + 1'b1;
        end
        ST_RCAS: state <= ST_RRAS;
        ST_RRAS: begin
          if (cnt == CNT_W'(RAS_CYC - 1)) begin cnt <= '0; state <= ST_PRE; end
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_CLOSED;
      endcase
    end
  end

  // Column cycle: first cycle is address/write setup, CAS low afterwards.
  assign cas_phase   = (state == ST_COL) && (cnt != '0);
  assign ref_ack     = (state == ST_RCAS);
  assign dram_ras_n  = !(state inside {ST_ACT, ST_COL, ST_OPEN, ST_RRAS});
  assign dram_lcas_n = !((cas_phase && (!we_q || be_q[0])) || state inside {ST_RCAS, ST_RRAS});
  assign dram_ucas_n = !((cas_phase && (!we_q || be_q[1])) || state inside {ST_RCAS, ST_RRAS});
  assign dram_we_n   = !((state == ST_COL) && we_q);
  assign dram_oe_n   = !(cas_phase && !we_q);
  assign dram_dq_oe  = (state == ST_COL) && we_q;
  assign dram_dq_out = wd_q;
  assign dram_a      = (state == ST_COL) ? col_q : open_row;

  assert_oe_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> dram_we_n);
  assert_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(dram_lcas_n) || $fell(dram_ucas_n)) && !dram_we_n) |-> $past(!dram_we_n));
  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_lcas_n) |-> $past(!dram_lcas_n && !dram_ucas_n));
  assert_hit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !dram_ras_n && !null_wr) |-> (req_row == dram_a));
  assert_null_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && null_wr) |=> (dram_lcas_n && dram_ucas_n));
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/fpdram_ctl.sv
`timescale 1ns/1ps
module fpdram_ctl
  import fpdram_pkg::*;
#(
  parameter int CLK_NS        = 20,
  parameter int RAC_NS        = 50,
  parameter int CAC_NS        = 13,
  parameter int RC_NS         = 90,
  parameter int REF_WINDOW_NS = 8_200_000,
  parameter int REF_ROWS      = 512,
  parameter int POSTPONE_MAX  = 3,
  parameter int ROW_W         = 9,
  parameter int COL_W         = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [BE_W-1:0]        req_be,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ROW_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_lcas_n,
  output logic                   dram_ucas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int RCD_CYC  = ns2cyc(RAC_NS - CAC_NS, CLK_NS);
  localparam int CAC_CYC  = ns2cyc(CAC_NS, CLK_NS);
  localparam int RP_CYC   = ns2cyc(RC_NS - RAC_NS, CLK_NS);
  localparam int RAS_CYC  = ns2cyc(RAC_NS, CLK_NS);
  localparam int INTERVAL = REF_WINDOW_NS / REF_ROWS / CLK_NS;

  logic ref_need, ref_urgent, ref_ack;

  fpdram_refresh #(.INTERVAL(INTERVAL), .LIMIT(POSTPONE_MAX)) u_refresh (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack),
    .ref_need(ref_need), .ref_urgent(ref_urgent)
  );

  fpdram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .RCD_CYC(RCD_CYC),
    .CAC_CYC(CAC_CYC), .RP_CYC(RP_CYC), .RAS_CYC(RAS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_need(ref_need), .ref_urgent(ref_urgent), .ref_ack(ref_ack),
    .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );
endmodule

// File: tb/fpdram_ctl_tb.sv
`timescale 1ns/1ps
module fpdram_ctl_tb_top;
  localparam int EXP_RP   = 2;   // ceil((90-50)/20)
  localparam int EXP_CAC  = 1;   // ceil(13/20)
  localparam int INTV     = 200; // 2_048_000 / 512 / 20
  localparam int LIM      = 3;

  // {we, be[1:0], addr[17:0], wdata[15:0], expected read[15:0]}
  localparam logic [52:0] VEC [0:11] = '{
    {1'b1, 2'b11, 18'h00005, 16'hA5A5, 16'h0000},
    {1'b1, 2'b11, 18'h00006, 16'h1234, 16'h0000},
    {1'b1, 2'b01, 18'h00005, 16'h00FF, 16'h0000},
    {1'b1, 2'b10, 18'h00006, 16'hBE00, 16'h0000},
    {1'b1, 2'b11, 18'h20005, 16'h7777, 16'h0000},
    {1'b1, 2'b00, 18'h00005, 16'hFFFF, 16'h0000},
    {1'b1, 2'b11, 18'h3FFFF, 16'hC3C3, 16'h0000},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA5FF},
    {1'b0, 2'b11, 18'h00006, 16'h0000, 16'hBE34},
    {1'b0, 2'b11, 18'h20005, 16'h0000, 16'h7777},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'hC3C3},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA5FF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [1:0] req_be = 2'b00;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_lcas_n, dram_ucas_n;
  logic dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] rsp_rdata, dram_dq_out;
  logic [15:0] mdl_dq = '0;
  logic [8:0] dram_a;

  always #10 clk = ~clk;

  fpdram_ctl #(.REF_WINDOW_NS(2_048_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(mdl_dq)
  );

  int total = 0, bad = 0;
  int cyc = 0, act_cnt = 0, ref_cnt = 0, cas_cnt = 0;
  int cbr_bad = 0, ew_bad = 0, oe_bad = 0;
  int rise_cyc = 0, last_gap = 0, fall_cyc = 0, rsp_cyc = 0;
  logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
  logic [8:0] mdl_row = '0;
  logic [15:0] mem [int];

  function automatic logic [15:0] lookup(int k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  // Behavioural memory and pin monitor, sampling values held over the last cycle.
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!dram_oe_n && !dram_we_n) oe_bad++;
      if (!dram_ras_n && p_ras) begin
        if (!dram_lcas_n) begin
          ref_cnt++;
          if (!(p_l == 1'b0 && p_u == 1'b0 && dram_ucas_n == 1'b0)) cbr_bad++;
        end else begin
          act_cnt++;
          mdl_row = dram_a;
          last_gap = cyc - rise_cyc;
        end
      end
      if (dram_ras_n && !p_ras) rise_cyc = cyc;
      if (!dram_ras_n && ((!dram_lcas_n && p_l) || (!dram_ucas_n && p_u))) begin
        cas_cnt++;
        fall_cyc = cyc;
        if (!dram_we_n) begin
          logic [15:0] w;
          int k;
          if (p_we || !dram_dq_oe) ew_bad++;
          k = int'({mdl_row, dram_a});
          w = lookup(k);
          if (!dram_lcas_n) w[7:0] = dram_dq_out[7:0];
          if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
          mem[k] = w;
        end
      end
      if (rsp_valid) rsp_cyc = cyc;
    end
    p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
  end

  always @(negedge clk)
    mdl_dq <= (!dram_oe_n && !dram_ras_n) ? lookup(int'({mdl_row, dram_a})) : 16'h0000;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [1:0] be, input logic [17:0] a,
                        input logic [15:0] wd, output int waited, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = wd;
    #1;
    waited = 0;
    while (!req_ready && waited < 200) begin
      @(negedge clk); #1; waited++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = 16'h0;
    if (!we) begin
      for (int t = 0; t < 40 && !rsp_valid; t++) @(negedge clk);
      rd = rsp_rdata;
      chk(rsp_valid, "R6 response seen", rsp_valid, 1);
      @(negedge clk);
      chk(!rsp_valid, "R6 single-cycle valid", rsp_valid, 0);
      chk(rsp_cyc - fall_cyc == EXP_CAC, "R6 capture delay", rsp_cyc - fall_cyc, EXP_CAC);
    end else repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w, c0, a0, r0, cy0, mism;
    logic [15:0] rd;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n && !dram_dq_oe
        && !rsp_valid, "R1 reset pins", {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n,
        dram_oe_n, dram_dq_oe, rsp_valid}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && !req_ready == 1'b0, "R1 after reset",
        {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'b111);

    // Vector table: writes with masks, then read-back.
    for (int i = 0; i < 12; i++) begin
      logic [52:0] v;
      v = VEC[i];
      c0 = cas_cnt;
      do_req(v[52], v[51:50], v[49:32], v[31:16], w, rd);
      if (v[52]) begin
        chk(cas_cnt - c0 == ((v[51:50] != 2'b00) ? 1 : 0), "R4 CAS pulses per write",
            cas_cnt - c0, (v[51:50] != 2'b00) ? 1 : 0);
        if (i == 4) chk(w > 0, "R9 miss held off", w, 1);
      end else begin
        chk(rd == v[15:0], "R4 read data", rd, v[15:0]);
        chk(cas_cnt - c0 == 1, "R4 read strobes", cas_cnt - c0, 1);
        if (i == 10) chk(mdl_row == 9'h1FF, "R2 row address bits", mdl_row, 9'h1FF);
      end
    end

    // Page hit and precharge gap (R3).
    r0 = ref_cnt;
    for (int t = 0; t < 400 && ref_cnt == r0; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    do_req(1'b0, 2'b11, 18'h00005, 16'h0, w, rd);
    a0 = act_cnt;
    do_req(1'b0, 2'b11, 18'h00006, 16'h0, w, rd);
    chk(act_cnt == a0, "R3 page hit no activation", act_cnt - a0, 0);
    chk(rd == 16'hBE34, "R3 hit data", rd, 16'hBE34);
    do_req(1'b0, 2'b11, 18'h20005, 16'h0, w, rd);
    chk(act_cnt == a0 + 1, "R3 miss activates", act_cnt - a0, 1);
    chk(last_gap >= EXP_RP, "R3 precharge gap", last_gap, EXP_RP);
    chk(rd == 16'h7777, "R2 miss data", rd, 16'h7777);

    // Idle refresh rate (R7).
    r0 = ref_cnt;
    repeat (2000) @(negedge clk);
    chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R7 idle refresh rate", ref_cnt - r0, 10);
    chk(cbr_bad == 0, "R7 CAS before RAS", cbr_bad, 0);

    // Continuous misses: refresh deferred but bounded (R8).
    r0 = ref_cnt; cy0 = cyc; mism = 0;
    for (int n = 0; n < 150; n++) begin
      do_req(1'b0, 2'b11, (n % 2) ? 18'h20005 : 18'h00005, 16'h0, w, rd);
      if (rd != ((n % 2) ? 16'h7777 : 16'hA5FF)) mism++;
    end
    chk(mism == 0, "R8 data under refresh", mism, 0);
    chk(ref_cnt - r0 >= (cyc - cy0) / INTV - LIM - 1 && ref_cnt - r0 <= (cyc - cy0) / INTV + 1,
        "R8 refresh budget", ref_cnt - r0, (cyc - cy0) / INTV);

    chk(ew_bad == 0, "R5 early write", ew_bad, 0);
    chk(oe_bad == 0, "R5 output enable only on reads", oe_bad, 0);

    // Reset in mid-run (R1).
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n && !rsp_valid,
        "R1 mid-run reset", {dram_ras_n, dram_lcas_n}, 2'b11);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule